// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a 32-bit processor core and a data memory that is byte addressed and one 32-bit word wide. On the request side it forms the effective address from a base register value and a signed 12-bit offset. From that address, the access code and the source register it then produces four results: a word-aligned memory address, write data placed in the proper byte lanes, a 4-bit byte-enable mask and a flag for a misaligned access. The low two address bits are returned as well, so the core can keep them until the load data comes back.

On the response side the block takes the raw memory word, the saved low address bits and the access code. It returns the byte or halfword that was addressed, sign-extended or zero-extended to 32 bits, or the whole word. Byte order is little-endian. Every output is registered, and each one appears one clock after the inputs that produced it. The access code uses the usual 3-bit function encoding: 000 byte, 001 halfword, 010 word, 100 unsigned byte, 101 unsigned halfword.

Top module: `lsu_lane_align`

## Requirements
- R1: One clock after the request inputs, mem_addr_o holds ea = base_i + sign-extended offset_i (modulo 2^32) with bits [1:0] cleared, and ea_lo_o holds ea[1:0].
- R2: A byte store (fn_i=000, st_en_i=1) sets mem_be_o = 0001 shifted left by ea[1:0], and mem_wdata_o repeats wdata_i[7:0] in all four byte lanes.
- R3: An aligned halfword store (fn_i=001, ea[0]=0) sets mem_be_o to 0011 when ea[1]=0 and to 1100 when ea[1]=1. mem_wdata_o holds wdata_i[15:0] in both halves.
- R4: An aligned word store (fn_i=010, ea[1:0]=00) sets mem_be_o=1111 and passes wdata_i through unchanged.
- R5: misalign_o is raised when fn_i[1:0]=01 and ea[0]=1, or when fn_i[1:0]=10 and ea[1:0]≠00. This holds whether or not st_en_i is set. While misalign_o is high, mem_be_o is 0000.
- R6: With st_en_i=0, or with any fn_i other than 000, 001 or 010, mem_be_o is 0000.
- R7: A byte load returns byte lane ld_lo_i of rdata_i. Code 000 sign-extends it from bit 7 and code 100 zero-extends it.
- R8: A halfword load returns rdata_i[15:0] when ld_lo_i[1]=0 and rdata_i[31:16] when ld_lo_i[1]=1; ld_lo_i[0] is ignored. Code 001 sign-extends the result from bit 15 and code 101 zero-extends it.
- R9: A word load (ld_fn_i=010) returns rdata_i unchanged. Codes 011, 110 and 111 return zero.
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_en_i | input | 1 | Store request; enables the byte lanes |
| fn_i | input | 3 | Request access code |
| base_i | input | 32 | Base register value |
| offset_i | input | 12 | Signed address offset |
| wdata_i | input | 32 | Source register for stores |
| mem_addr_o | output | 32 | Word-aligned memory address |
| ea_lo_o | output | 2 | Low bits of the effective address |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_be_o | output | 4 | Byte enables, bit i for byte lane i |
| misalign_o | output | 1 | Misaligned halfword or word access |
| ld_fn_i | input | 3 | Load access code |
| ld_lo_i | input | 2 | Saved low address bits of the load |
| rdata_i | input | 32 | Raw memory word |
| ld_value_o | output | 32 | Extracted and extended load value |

## Verification
The assertions assume that the request and load inputs stay stable from one rising edge to the next. They also assume that fn_i and ld_fn_i are always known 3-bit values, so every code, the unused ones included, stands for a defined behaviour. The stimulus changes inputs only on the falling clock edge. It sweeps all eight codes, with st_en_i both set and clear, against bases and offsets chosen so that every low-bit value occurs and the address wraps across the top of the address space. Load data patterns put ones and zeros in the sign bit of each lane.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int XLEN   = 32;
    localparam int OFFW   = 12;
    localparam int NBYTES = XLEN / 8;
    localparam int LOW    = $clog2(NBYTES);

    typedef struct packed {
        logic [XLEN-1:0]   addr;
        logic [LOW-1:0]    lo;
        logic [XLEN-1:0]   wdata;
        logic [NBYTES-1:0] be;
        logic              mis;
        logic [XLEN-1:0]   ldval;
    } lsu_out_t;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0] base_i,
    input  logic [OFFW-1:0] offset_i,
    output logic [XLEN-1:0] ea_o
);
    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext = {{(XLEN-OFFW){offset_i[OFFW-1]}}, offset_i};
        ea_o    = base_i + off_ext;
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  logic              en_i,
    input  logic [2:0]        fn_i,
    input  logic [LOW-1:0]    lo_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   wdata_o,
    output logic [NBYTES-1:0] be_o,
    output logic              mis_o
);
    logic [NBYTES-1:0] be_raw;

    always_comb begin
        mis_o  = 1'b0;
        be_raw = '0;
        case (fn_i[1:0])
            2'b00: be_raw = 4'b0001 << lo_i;
            2'b01: begin
                mis_o  = lo_i[0];
                be_raw = 4'b0011 << {lo_i[1], 1'b0};
            end
            2'b10: begin
                mis_o  = |lo_i;
                be_raw = 4'b1111;
            end
            default: be_raw = '0;
        endcase
        be_o = (en_i && !fn_i[2] && !mis_o) ? be_raw : '0;
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int HB = i % 2;
        always_comb begin
            case (fn_i[1:0])
                2'b00:   wdata_o[i*8 +: 8] = wdata_i[7:0];
                2'b01:   wdata_o[i*8 +: 8] = wdata_i[HB*8 +: 8];
                default: wdata_o[i*8 +: 8] = wdata_i[i*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [2:0]      fn_i,
    input  logic [LOW-1:0]  lo_i,
    input  logic [XLEN-1:0] rdata_i,
    output logic [XLEN-1:0] value_o
);
    logic [XLEN-1:0] bsh;
    logic [XLEN-1:0] hsh;
    logic [7:0]      b;
    logic [15:0]     h;

    always_comb begin
        bsh = rdata_i >> {lo_i, 3'b000};
        hsh = rdata_i >> {lo_i[1], 4'b0000};
        b   = bsh[7:0];
        h   = hsh[15:0];
        case (fn_i)
            3'b000:  value_o = {{(XLEN-8){b[7]}}, b};
            3'b100:  value_o = {{(XLEN-8){1'b0}}, b};
            3'b001:  value_o = {{(XLEN-16){h[15]}}, h};
            3'b101:  value_o = {{(XLEN-16){1'b0}}, h};
            3'b010:  value_o = rdata_i;
            default: value_o = '0;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en_i,
    input  logic [2:0]        fn_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [OFFW-1:0]   offset_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [LOW-1:0]    ea_lo_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    output logic [NBYTES-1:0] mem_be_o,
    output logic              misalign_o,
    input  logic [2:0]        ld_fn_i,
    input  logic [LOW-1:0]    ld_lo_i,
    input  logic [XLEN-1:0]   rdata_i,
    output logic [XLEN-1:0]   ld_value_o
);
    logic [XLEN-1:0]   ea;
    logic [XLEN-1:0]   st_wdata;
    logic [NBYTES-1:0] st_be;
    logic              st_mis;
    logic [XLEN-1:0]   ld_val;
    lsu_out_t          out_d, out_q;

    lsu_ea_gen u_ea (
        .base_i   (base_i),
        .offset_i (offset_i),
        .ea_o     (ea)
    );

    lsu_store_lanes u_st (
        .en_i    (st_en_i),
        .fn_i    (fn_i),
        .lo_i    (ea[LOW-1:0]),
        .wdata_i (wdata_i),
        .wdata_o (st_wdata),
        .be_o    (st_be),
        .mis_o   (st_mis)
    );

    lsu_load_extract u_ld (
        .fn_i    (ld_fn_i),
        .lo_i    (ld_lo_i),
        .rdata_i (rdata_i),
        .value_o (ld_val)
    );

    always_comb begin
        out_d       = out_q;
        out_d.addr  = {ea[XLEN-1:LOW], {LOW{1'b0}}};
        out_d.lo    = ea[LOW-1:0];
        out_d.wdata = st_wdata;
        out_d.be    = st_be;
        out_d.mis   = st_mis;
        out_d.ldval = ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mem_addr_o  = out_q.addr;
    assign ea_lo_o     = out_q.lo;
    assign mem_wdata_o = out_q.wdata;
    assign mem_be_o    = out_q.be;
    assign misalign_o  = out_q.mis;
    assign ld_value_o  = out_q.ldval;

    a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en_i && fn_i == 3'b000) |=> ($countones(mem_be_o) == 1));

    a_r3_half_lane_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en_i && fn_i == 3'b001 && !ea[0]) |=> (mem_be_o == 4'b0011 || mem_be_o == 4'b1100));

    a_r5_misaligned_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (mem_be_o == '0));

    a_r6_disabled_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_en_i) |=> (mem_be_o == '0));

    a_r7_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fn_i == 3'b000) |=> (ld_value_o[XLEN-1:7] == '0 || (&ld_value_o[XLEN-1:7])));

    a_r8_half_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fn_i == 3'b101) |=> (ld_value_o[XLEN-1:16] == '0));

    a_r9_word_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fn_i == 3'b010) |=> (ld_value_o == $past(rdata_i)));
endmodule

// File: tb/lsu_lane_align_bench.sv
`timescale 1ns/1ps
module lsu_lane_align_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_en_i = 1'b0;
    logic [2:0]  fn_i = '0;
    logic [31:0] base_i = '0;
    logic [11:0] offset_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] mem_addr_o;
    logic [1:0]  ea_lo_o;
    logic [31:0] mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic        misalign_o;
    logic [2:0]  ld_fn_i = '0;
    logic [1:0]  ld_lo_i = '0;
    logic [31:0] rdata_i = '0;
    logic [31:0] ld_value_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lsu_lane_align u_lsu_lane_align (
        .clk (clk), .rst_n (rst_n), .st_en_i (st_en_i), .fn_i (fn_i),
        .base_i (base_i), .offset_i (offset_i), .wdata_i (wdata_i),
        .mem_addr_o (mem_addr_o), .ea_lo_o (ea_lo_o), .mem_wdata_o (mem_wdata_o),
        .mem_be_o (mem_be_o), .misalign_o (misalign_o), .ld_fn_i (ld_fn_i),
        .ld_lo_i (ld_lo_i), .rdata_i (rdata_i), .ld_value_o (ld_value_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] bases [4];
        logic [11:0] offs  [8];
        logic [31:0] datas [5];
        logic [31:0] ea, e_wd, e_val, bsh, hsh;
        logic [3:0]  e_be;
        logic        e_mis;
        logic [1:0]  lo;
        string       btag;

        bases = '{32'h1000_0000, 32'hFFFF_FFFF, 32'h0000_0003, 32'h7FFF_FFFE};
        offs  = '{12'h000, 12'h001, 12'h002, 12'h003, 12'h7FF, 12'h800, 12'hFFF, 12'h005};
        datas = '{32'h80FF_7F01, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7F80_8001};

        base_i  = 32'hDEAD_BEEF;
        wdata_i = 32'hA5A5_A5A5;
        rdata_i = 32'hFFFF_FFFF;
        st_en_i = 1'b1;
        fn_i    = 3'b010;
        ld_fn_i = 3'b010;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset holds every output at zero
        chk("R10 addr", mem_addr_o, 32'h0);
        chk("R10 lo", {30'h0, ea_lo_o}, 32'h0);
        chk("R10 wdata", mem_wdata_o, 32'h0);
        chk("R10 be", {28'h0, mem_be_o}, 32'h0);
        chk("R10 mis", {31'h0, misalign_o}, 32'h0);
        chk("R10 ldval", ld_value_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int bi = 0; bi < 4; bi++) begin
            for (int oi = 0; oi < 8; oi++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int en = 0; en < 2; en++) begin
                        @(negedge clk);
                        base_i   = bases[bi];
                        offset_i = offs[oi];
                        fn_i     = f[2:0];
                        st_en_i  = en[0];
                        wdata_i  = 32'hC3B2_A190 ^ (bases[bi] << oi) ^ {29'h0, f[2:0]};
                        ea    = bases[bi] + {{20{offs[oi][11]}}, offs[oi]};
                        lo    = ea[1:0];
                        e_mis = (f[1:0] == 2'b01 && lo[0]) || (f[1:0] == 2'b10 && lo != 2'b00);
                        case (f[1:0])
                            2'b00:   e_wd = {4{wdata_i[7:0]}};
                            2'b01:   e_wd = {2{wdata_i[15:0]}};
                            default: e_wd = wdata_i;
                        endcase
                        if (!en[0] || f[2] || f[1:0] == 2'b11 || e_mis) e_be = 4'b0000;
                        else if (f[1:0] == 2'b00) e_be = 4'b0001 << lo;
                        else if (f[1:0] == 2'b01) e_be = lo[1] ? 4'b1100 : 4'b0011;
                        else e_be = 4'b1111;
                        if (!en[0] || f[2] || f[1:0] == 2'b11) btag = "R6 be";
                        else if (e_mis) btag = "R5 be";
                        else if (f[1:0] == 2'b00) btag = "R2 be";
                        else if (f[1:0] == 2'b01) btag = "R3 be";
                        else btag = "R4 be";
                        @(posedge clk);
                        #1;
                        chk("R1 addr", mem_addr_o, {ea[31:2], 2'b00});
                        chk("R1 lo", {30'h0, ea_lo_o}, {30'h0, lo});
                        chk(btag, {28'h0, mem_be_o}, {28'h0, e_be});
                        chk("R5 mis", {31'h0, misalign_o}, {31'h0, e_mis});
                        if (f[1:0] == 2'b00) chk("R2 wdata", mem_wdata_o, e_wd);
                        else if (f[1:0] == 2'b01) chk("R3 wdata", mem_wdata_o, e_wd);
                        else if (f[1:0] == 2'b10) chk("R4 wdata", mem_wdata_o, e_wd);
                    end
                end
            end
        end

        for (int di = 0; di < 5; di++) begin
            for (int f = 0; f < 8; f++) begin
                for (int l = 0; l < 4; l++) begin
                    @(negedge clk);
                    rdata_i = datas[di];
                    ld_fn_i = f[2:0];
                    ld_lo_i = l[1:0];
                    bsh = datas[di] >> (8 * l);
                    hsh = datas[di] >> (16 * (l / 2));
                    case (f[2:0])
                        3'b000:  e_val = {{24{bsh[7]}}, bsh[7:0]};
                        3'b100:  e_val = {24'h0, bsh[7:0]};
                        3'b001:  e_val = {{16{hsh[15]}}, hsh[15:0]};
                        3'b101:  e_val = {16'h0, hsh[15:0]};
                        3'b010:  e_val = datas[di];
                        default: e_val = 32'h0;
                    endcase
                    @(posedge clk);
                    #1;
                    if (f[1:0] == 2'b00) chk("R7 ldval", ld_value_o, e_val);
                    else if (f[1:0] == 2'b01) chk("R8 ldval", ld_value_o, e_val);
                    else chk("R9 ldval", ld_value_o, e_val);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule